// File: doc/BRIEF.md
# Byte-Wide Memory with Nonvolatile Shadow Array

This block is a 512-location, 8-bit static memory. Every location has a shadow copy in a second array that stands in for nonvolatile storage. A clocked host port carries four active-low strobes: chip select, output enable, write enable and nonvolatile enable. It also carries a 9-bit address, an input byte, an output byte and an output-valid flag. The flag takes the place of a tri-state data bus.

The strobes are decoded on each rising clock edge into one of these modes:
- byte read
- byte write
- whole-array recall (shadow to RAM)
- whole-array store (RAM to shadow)
- output disabled
- no operation

Recall and store run a copy engine that moves one location per cycle. The engine then keeps `busy` high for the rest of a fixed duration, given in cycles by a parameter. A recall is about a thousand times shorter than a store. Reset clears the RAM array but not the shadow array, so a recall after reset brings the last stored image back.

Top module: `nvShadowRam`

## Requirements
- R1: After reset, `busy` is 0, `dOutValid` is 0, and every RAM location reads back as 0x00.
- R2: With `ceN`=0, `oeN`=0, `weN`=1 and `neN`=1 at a clock edge, the edge after it shows `dOutValid`=1 and `dOut` equal to the byte stored at `addr`.
- R3: With `ceN`=0, `weN`=0 and `neN`=1 at a clock edge, the byte on `dIn` is written to `addr`, whatever the level of `oeN`.
- R4: `dOutValid` is 0 after any edge where `ceN`=1, `oeN`=1 or `neN`=0, including every cycle of a recall or a store. With `ceN`=1, nothing is written regardless of the other strobes.
- R5: All four strobes low together is a no-operation. It starts no copy (`busy` stays 0), writes nothing and leaves `dOutValid` at 0.
- R6: With `ceN`=0, `oeN`=0, `neN`=0 and `weN`=1 while idle, the block copies every shadow location into RAM. `busy` is high for exactly `RECALL_CYC` cycles, starting at the next edge.
- R7: With `ceN`=0, `weN`=0, `neN`=0 and `oeN`=1 while idle, the block copies every RAM location into the shadow array. `busy` is high for exactly `STORE_CYC` cycles.
- R8: While `busy` is 1, host reads, writes, recalls and stores are all ignored. No byte changes, no output appears, and no new copy starts once `busy` falls.
- R9: Reset leaves the shadow array unchanged, so a recall after reset restores the last stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears RAM only |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable / recall strobe, active low |
| weN | input | 1 | Write enable / store strobe, active low |
| neN | input | 1 | Nonvolatile enable, active low |
| addr | input | 9 | Byte address |
| dIn | input | 8 | Write data |
| dOut | output | 8 | Read data, registered |
| dOutValid | output | 1 | Output drive flag (stands in for bus enable) |
| busy | output | 1 | Recall or store in progress |

## Verification
The hardest situation to reach is showing that the shadow array really survives: its contents can only be seen through a recall into RAM. The stimulus therefore writes a computed pattern to all 512 locations and stores it. It then damages RAM both by direct writes and by reset, and recalls. Reads of the first, last and scattered addresses must show the stored pattern again. Requests issued in the middle of a long store are followed by reads after `busy` falls, which shows that those requests left no trace.

// File: rtl/nvShadowPkg.sv
package nvShadowPkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_READ,
    MODE_WRITE,
    MODE_RECALL,
    MODE_STORE,
    MODE_NOP
  } hostMode_t;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic ramWr;
    logic rdEn;
    logic copyRecall;
    logic copyStore;
  } dpStrobe_t;

  function automatic hostMode_t decodeMode(input logic ceN, input logic oeN,
                                           input logic weN, input logic neN);
    hostMode_t m;
    if (ceN)                    m = MODE_OFF;
    else if (neN && !weN)       m = MODE_WRITE;
    else if (neN && !oeN)       m = MODE_READ;
    else if (!neN && !oeN && weN) m = MODE_RECALL;
    else if (!neN && oeN && !weN) m = MODE_STORE;
    else                        m = MODE_NOP;
    return m;
  endfunction

endpackage

// File: rtl/nvsCtrl.sv
module nvsCtrl
  import nvShadowPkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int RECALL_CYC = 640,
  parameter int STORE_CYC  = 640000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              neN,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] copyIdx,
  output logic              busy
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MAXCYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W  = $clog2(MAXCYC + 1) > ADDR_W ? $clog2(MAXCYC + 1) : ADDR_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_RECALL, S_STORE} engState_t;

  engState_t  state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  hostMode_t  mode;

  always_comb begin
    mode = decodeMode(ceN, oeN, weN, neN);
  end

  assign busy    = (state != S_IDLE);
  assign lastCnt = (state == S_STORE) ? CNT_W'(STORE_CYC - 1) : CNT_W'(RECALL_CYC - 1);
  assign copyIdx = cnt[ADDR_W-1:0];

  always_comb begin
    stb            = '0;
    stb.ramWr      = !busy && (mode == MODE_WRITE);
    stb.rdEn       = !busy && (mode == MODE_READ);
    stb.copyRecall = (state == S_RECALL) && (cnt < CNT_W'(DEPTH));
    stb.copyStore  = (state == S_STORE)  && (cnt < CNT_W'(DEPTH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (mode == MODE_RECALL)     state <= S_RECALL;
          else if (mode == MODE_STORE) state <= S_STORE;
        end
        default: begin
          if (cnt == lastCnt) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R5: the forbidden all-low combination never starts a copy
  a_r5_forbidden_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !ceN && !oeN && !weN && !neN) |=> !busy);
  // R6: recall strobe while idle raises busy next cycle
  a_r6_recall_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !ceN && !oeN && weN && !neN) |=> busy);
  // R7: store strobe while idle raises busy next cycle
  a_r7_store_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !ceN && oeN && !weN && !neN) |=> busy);
  // R8: no host access gets through while a copy runs
  a_r8_host_blocked: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!stb.ramWr && !stb.rdEn));

endmodule

// File: rtl/nvsDatapath.sv
module nvsDatapath
  import nvShadowPkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] copyIdx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ramArr    [DEPTH];
  logic [DATA_W-1:0] shadowArr [DEPTH];

  // volatile array: cleared by reset, written by host or by recall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ramArr[i] <= '0;
    end else if (stb.ramWr) begin
      ramArr[addr] <= dIn;
    end else if (stb.copyRecall) begin
      ramArr[copyIdx] <= shadowArr[copyIdx];
    end
  end

  // shadow array: deliberately outside reset
  always_ff @(posedge clk) begin
    if (stb.copyStore) shadowArr[copyIdx] <= ramArr[copyIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut      <= '0;
      dOutValid <= 1'b0;
    end else begin
      dOutValid <= stb.rdEn;
      if (stb.rdEn) dOut <= ramArr[addr];
    end
  end

  // R8: copy engine and host write never meet in one cycle
  a_r8_no_collision: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ramWr && (stb.copyRecall || stb.copyStore)));

endmodule

// File: rtl/nvShadowRam.sv
module nvShadowRam
  import nvShadowPkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int RECALL_CYC = 640,
  parameter int STORE_CYC  = 640000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              neN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutValid,
  output logic              busy
);
  dpStrobe_t         stb;
  logic [ADDR_W-1:0] copyIdx;

  nvsCtrl #(
    .ADDR_W(ADDR_W), .RECALL_CYC(RECALL_CYC), .STORE_CYC(STORE_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .neN(neN),
    .stb(stb), .copyIdx(copyIdx), .busy(busy)
  );

  nvsDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .copyIdx(copyIdx), .addr(addr),
    .dIn(dIn), .dOut(dOut), .dOutValid(dOutValid)
  );

  // R4: output is driven only after a plain read request
  a_r4_out_gate: assert property (@(posedge clk) disable iff (!rstN)
    dOutValid |-> $past(!ceN && !oeN && weN && neN));
  // R2: a valid output never coincides with a running copy
  a_r2_out_idle: assert property (@(posedge clk) disable iff (!rstN)
    dOutValid |-> !busy);

endmodule

// File: tb/test_nvShadowRam.sv
module test_nvShadowRam;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 9;
  localparam int DW   = 8;
  localparam int DEP  = 1 << AW;
  localparam int RCYC = 600;
  localparam int SCYC = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, neN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic dOutValid, busy;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  typedef struct { logic [DW-1:0] val; string tag; } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvShadowRam #(.ADDR_W(AW), .DATA_W(DW), .RECALL_CYC(RCYC), .STORE_CYC(SCYC)) i_nvShadowRam (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .neN(neN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOutValid(dOutValid), .busy(busy)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 37 + 11);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the output is driven
  always @(negedge clk) begin
    if (rstN && dOutValid) begin
      if (expQ.size() == 0) begin
        check("R4 unexpected output", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, dOut, e.val);
      end
    end
  end

  task automatic setIdle();
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1; neN = 1'b1;
  endtask

  task automatic drive(input logic c, input logic o, input logic w, input logic n,
                       input int a, input int d);
    @(negedge clk);
    ceN = c; oeN = o; weN = w; neN = n; addr = AW'(a); dIn = DW'(d);
    @(negedge clk);
    setIdle();
  endtask

  task automatic writeB(input int a, input int d, input logic o);
    drive(1'b0, o, 1'b0, 1'b1, a, d);
  endtask

  task automatic readB(input int a, input int exp, input string tag);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; neN = 1'b1; addr = AW'(a);
    expQ.push_back('{val: DW'(exp), tag: tag});
    @(negedge clk);
    setIdle();
    #1;
    if (expQ.size() != 0) begin
      check({tag, " no output"}, 0, 1);
      expQ.delete();
    end
  endtask

  // measures busy length; pokes blocked requests while busy if asked
  task automatic runCopy(input logic isStore, input int expLen, input string tag,
                         input bit poke);
    int n = 0;
    int outSeen = 0;
    drive(1'b0, isStore, !isStore, 1'b0, 0, 0);
    while (busy) begin
      n++;
      if (dOutValid) outSeen++;
      if (poke && n == 20) begin ceN = 0; oeN = 1; weN = 0; neN = 1; addr = 3; dIn = 8'hEE; end
      else if (poke && n == 21) begin ceN = 0; oeN = 0; weN = 1; neN = 1; addr = 3; end
      else if (poke && n == expLen - 1) begin ceN = 0; oeN = 0; weN = 1; neN = 0; end
      else setIdle();
      @(negedge clk);
    end
    setIdle();
    check({tag, " busy length"}, n, expLen);
    check("R4 no output during copy", outSeen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 dOutValid after reset", dOutValid, 0);
    readB(0, 0, "R1 ram cleared addr 0");
    readB(DEP-1, 0, "R1 ram cleared addr last");

    // fill, alternating oeN to show it is ignored for writes
    for (int a = 0; a < DEP; a++) writeB(a, pat(a), a[0]);
    readB(0, pat(0), "R3 write addr 0");
    readB(1, pat(1), "R3 write with oeN low");
    readB(DEP-1, pat(DEP-1), "R2 read last");
    readB(200, pat(200), "R2 read mid");

    // not selected: write strobe with ceN high
    drive(1'b1, 1'b1, 1'b0, 1'b1, 5, 8'h00);
    readB(5, pat(5), "R4 ceN high no write");
    // output disabled mode
    drive(1'b0, 1'b1, 1'b1, 1'b1, 6, 0);
    check("R4 oeN high no output", dOutValid, 0);
    // read style with neN low is recall, not a read; checked in R6 run below
    // forbidden all-low
    drive(1'b0, 1'b0, 1'b0, 1'b0, 7, 8'h00);
    check("R5 forbidden no busy", busy, 0);
    check("R5 forbidden no output", dOutValid, 0);
    readB(7, pat(7), "R5 forbidden no write");

    // store with blocked requests inside
    runCopy(1'b1, SCYC, "R7", 1'b1);
    @(negedge clk);
    check("R8 recall during busy ignored", busy, 0);
    readB(3, pat(3), "R8 write during busy ignored");

    // damage RAM then recall
    writeB(0, 8'h00, 1'b1);
    writeB(3, 8'hFF, 1'b1);
    writeB(DEP-1, 8'h55, 1'b1);
    readB(3, 8'hFF, "R3 overwrite");
    runCopy(1'b0, RCYC, "R6", 1'b0);
    readB(0, pat(0), "R6 recall addr 0");
    readB(3, pat(3), "R6 recall addr 3");
    readB(DEP-1, pat(DEP-1), "R6 recall last");

    // reset keeps shadow
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readB(7, 0, "R9 ram cleared by reset");
    runCopy(1'b0, RCYC, "R9 recall", 1'b0);
    readB(7, pat(7), "R9 shadow kept addr 7");
    readB(300, pat(300), "R9 shadow kept addr 300");

    // second store picks up new RAM content
    writeB(100, 8'hC3, 1'b1);
    runCopy(1'b1, SCYC, "R7 second", 1'b0);
    writeB(100, 8'h00, 1'b1);
    runCopy(1'b0, RCYC, "R6 second", 1'b0);
    readB(100, 8'hC3, "R7 stored new byte");
    readB(101, pat(101), "R7 neighbour kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule